// File: doc/BRIEF.md
# Swappable DSP/DMA Buffer Memory

This block holds the working memory of a signal processor. One region of it may be shared with a DMA engine. The DSP port addresses twice the region size. The lower half of that space is a private scratch area that only the DSP can reach. The upper half is a window onto the shared region. The DMA port addresses only the shared region.

A three-bit control register decides who may use the shared region:

- Bit 0 set selects double-buffer mode. Clear selects single-buffer mode.
- In single-buffer mode, bit 1 hands the whole shared region to the DMA side when set, or to the DSP when clear.
- In double-buffer mode, the region splits into two halves. The DSP sees one half at the start of its window, and the DMA side sees the other half at its addresses 0 to half-1. Bit 2 exchanges the two halves without moving any data.

An access from a side that does not own the addressed space has no effect. A blocked read returns zero. Either kind of blocked access raises a sticky violation flag.

Top module: `pingpong_bufmem`

## Requirements
- R1: After reset, the control register reads 0 (single-buffer, DSP owner, no swap), the violation flag is 0, and both read data outputs are 0.
- R2: DSP addresses 0 to WORDS-1 form a private region that the DSP can read and write in every mode. Read data appears one clock after the request.
- R3: No DMA access changes any word of the private region.
- R4: In single-buffer mode with bit 1 clear, the DSP reaches all WORDS words of the shared region through addresses WORDS to 2*WORDS-1, and every DMA access is blocked.
- R5: In single-buffer mode with bit 1 set, the DMA side reaches all WORDS words at addresses 0 to WORDS-1, and DSP accesses to the shared window are blocked.
- R6: In double-buffer mode, the DSP reaches WORDS/2 words at window offsets 0 to WORDS/2-1. The DMA side reaches WORDS/2 words at addresses 0 to WORDS/2-1. DSP window offsets and DMA addresses of WORDS/2 and above are blocked.
- R7: Toggling bit 2 in double-buffer mode exchanges the halves seen by the two sides. Data written by one side becomes visible to the other at the same offset.
- R8: A blocked write leaves memory unchanged. A blocked read returns 0 one clock after the request.
- R9: The violation flag rises on the clock after any blocked access and stays set. A control register write clears it, unless a blocked access happens in the same cycle, in which case the flag stays set.
- R10: A control register write takes effect on the next cycle. An access made in the same cycle as the write is judged by the old setting.
- R11: In single-buffer mode, DSP window offset n and DMA address n refer to the same word. In double-buffer mode with bit 2 clear, the DSP half is single-mode offsets 0 to WORDS/2-1 and the DMA half is offsets WORDS/2 to WORDS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 3 | New control value: bit 0 double mode, bit 1 DMA owner, bit 2 swap |
| cfg_q | output | 3 | Current control register |
| viol | output | 1 | Sticky blocked-access flag |
| dsp_en | input | 1 | DSP access request |
| dsp_we | input | 1 | DSP write (1) or read (0) |
| dsp_addr | input | AW+1 (11) | DSP word address |
| dsp_wdata | input | DW (16) | DSP write data |
| dsp_rdata | output | DW (16) | DSP read data, one cycle after request |
| dma_en | input | 1 | DMA access request |
| dma_we | input | 1 | DMA write (1) or read (0) |
| dma_addr | input | AW (10) | DMA word address |
| dma_wdata | input | DW (16) | DMA write data |
| dma_rdata | output | DW (16) | DMA read data, one cycle after request |

## Verification
The hardest situation to reach is a control register write that coincides with accesses on both ports. In that cycle the old ownership must still apply, and the violation flag must be both cleared and set. The stimulus reaches it by issuing a DSP read, a DMA read and a control write in one cycle. It then checks the ownership change in the following cycle. The swap test writes both halves concurrently from the two sides, then toggles bit 2 and reads back each side's data through the other port.

// File: rtl/pingpong_bufmem.sv
module pingpong_bufmem #(
  parameter int DW    = 16,
  parameter int WORDS = 1024
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [2:0]             cfg_wdata,
  output logic [2:0]             cfg_q,
  output logic                   viol,
  input  logic                   dsp_en,
  input  logic                   dsp_we,
  input  logic [$clog2(WORDS):0] dsp_addr,
  input  logic [DW-1:0]          dsp_wdata,
  output logic [DW-1:0]          dsp_rdata,
  input  logic                   dma_en,
  input  logic                   dma_we,
  input  logic [$clog2(WORDS)-1:0] dma_addr,
  input  logic [DW-1:0]          dma_wdata,
  output logic [DW-1:0]          dma_rdata
);
  localparam int AW = $clog2(WORDS);
  localparam int HW = AW - 1;

  logic [DW-1:0] priv_mem [WORDS];
  logic [DW-1:0] swap_mem [WORDS];

  logic          dbl, own_dma, swp;
  logic          dsp_priv, dsp_ok, dma_ok;
  logic [AW-1:0] dsp_off, dsp_idx, dma_idx;

  assign dbl     = cfg_q[0];
  assign own_dma = cfg_q[1];
  assign swp     = cfg_q[2];

  assign dsp_priv = !dsp_addr[AW];
  assign dsp_off  = dsp_addr[AW-1:0];
  assign dsp_ok   = dsp_priv || (dbl ? !dsp_off[AW-1] : !own_dma);
  assign dsp_idx  = dbl ? {swp, dsp_off[HW-1:0]} : dsp_off;

  assign dma_ok   = dbl ? !dma_addr[AW-1] : own_dma;
  assign dma_idx  = dbl ? {!swp, dma_addr[HW-1:0]} : dma_addr;

  always_ff @(posedge clk) begin
    if (dsp_en && dsp_we && dsp_ok) begin
      if (dsp_priv) priv_mem[dsp_off] <= dsp_wdata;
      else          swap_mem[dsp_idx] <= dsp_wdata;
    end
    if (dma_en && dma_we && dma_ok)
      swap_mem[dma_idx] <= dma_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsp_rdata <= '0;
      dma_rdata <= '0;
    end else begin
      if (dsp_en && !dsp_we)
        dsp_rdata <= !dsp_ok ? '0 : dsp_priv ? priv_mem[dsp_off] : swap_mem[dsp_idx];
      if (dma_en && !dma_we)
        dma_rdata <= dma_ok ? swap_mem[dma_idx] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      viol  <= 1'b0;
    end else begin
      if (cfg_we) cfg_q <= cfg_wdata;
      if ((dsp_en && !dsp_ok) || (dma_en && !dma_ok)) viol <= 1'b1;
      else if (cfg_we)                                viol <= 1'b0;
    end
  end

  // R4
  single_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbl && !dsp_priv && dsp_ok) |-> !dma_ok);

  // R6
  halves_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbl && !dsp_priv && dsp_ok && dma_ok) |-> (dsp_idx[AW-1] != dma_idx[AW-1]));

  // R8
  dma_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && !dma_we && !dma_ok) |=> (dma_rdata == '0));

  // R8
  dsp_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_en && !dsp_we && !dsp_ok) |=> (dsp_rdata == '0));

  // R9
  viol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dsp_en && !dsp_ok) || (dma_en && !dma_ok)) |=> viol);

  // R10
  cfg_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q == $past(cfg_wdata)));

  // R3
  priv_only_dsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dsp_en |=> $stable(priv_mem[0]));
endmodule

// File: tb/pingpong_bufmem_bench.sv
module pingpong_bufmem_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_wdata = 0;
  logic [2:0]  cfg_q;
  logic        viol;
  logic        dsp_en = 0, dsp_we = 0;
  logic [10:0] dsp_addr = 0;
  logic [15:0] dsp_wdata = 0, dsp_rdata;
  logic        dma_en = 0, dma_we = 0;
  logic [9:0]  dma_addr = 0;
  logic [15:0] dma_wdata = 0, dma_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] q_dsp[$], q_dma[$];
  string       t_dsp[$], t_dma[$];

  always #2.5 clk = ~clk;

  pingpong_bufmem u_pingpong_bufmem (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic dsp_set(input bit we, input logic [10:0] a, input logic [15:0] d, input string req);
    dsp_en = 1; dsp_we = we; dsp_addr = a; dsp_wdata = d;
    if (!we) begin q_dsp.push_back(d); t_dsp.push_back(req); end
  endtask

  task automatic dma_set(input bit we, input logic [9:0] a, input logic [15:0] d, input string req);
    dma_en = 1; dma_we = we; dma_addr = a; dma_wdata = d;
    if (!we) begin q_dma.push_back(d); t_dma.push_back(req); end
  endtask

  task automatic cfg_set(input logic [2:0] v);
    cfg_we = 1; cfg_wdata = v;
  endtask

  task automatic go();
    @(posedge clk); #2;
    dsp_en = 0; dma_en = 0; cfg_we = 0;
  endtask

  always @(posedge clk) begin : monitor
    bit rd_d, rd_m;
    rd_d = rst_n && dsp_en && !dsp_we;
    rd_m = rst_n && dma_en && !dma_we;
    #1;
    if (rd_d) chk(dsp_rdata == q_dsp[0], t_dsp[0], dsp_rdata, q_dsp[0]);
    if (rd_d) begin void'(q_dsp.pop_front()); void'(t_dsp.pop_front()); end
    if (rd_m) chk(dma_rdata == q_dma[0], t_dma[0], dma_rdata, q_dma[0]);
    if (rd_m) begin void'(q_dma.pop_front()); void'(t_dma.pop_front()); end
  end

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    chk(cfg_q == 0, "R1 cfg", 16'(cfg_q), 0);
    chk(viol == 0, "R1 viol", 16'(viol), 0);
    chk(dsp_rdata == 0 && dma_rdata == 0, "R1 rdata", dsp_rdata | dma_rdata, 0);

    // R2 private region
    dsp_set(1, 11'd5, 16'h1111, ""); go();
    dsp_set(1, 11'd1023, 16'h2222, ""); go();
    dsp_set(0, 11'd5, 16'h1111, "R2 priv 5"); go();
    dsp_set(0, 11'd1023, 16'h2222, "R2 priv 1023"); go();

    // R4 single, DSP owner
    dsp_set(1, 11'h400, 16'hA000, ""); go();
    dsp_set(1, 11'h7FF, 16'hA3FF, ""); go();
    dsp_set(1, 11'h600, 16'hA200, ""); go();
    dsp_set(0, 11'h7FF, 16'hA3FF, "R4 dsp top"); go();
    dsp_set(0, 11'h600, 16'hA200, "R4 dsp mid"); go();
    dma_set(0, 10'd0, 16'h0000, "R4 dma blocked read"); go();
    chk(viol == 1, "R9 set", 16'(viol), 1);
    dma_set(1, 10'd0, 16'hDEAD, ""); go();
    cfg_set(3'b000); go();
    chk(viol == 0, "R9 clear", 16'(viol), 0);
    dsp_set(0, 11'h400, 16'hA000, "R8 blocked write ignored"); go();

    // R10 same-cycle cfg write with accesses
    cfg_set(3'b010);
    dsp_set(0, 11'h400, 16'hA000, "R10 old owner dsp");
    dma_set(0, 10'd0, 16'h0000, "R10 old owner dma");
    go();
    chk(cfg_q == 3'b010, "R10 cfg", 16'(cfg_q), 16'h2);
    chk(viol == 1, "R9 set wins", 16'(viol), 1);

    // R5 / R11 single, DMA owner
    dma_set(0, 10'd0, 16'hA000, "R11 same word"); go();
    dma_set(0, 10'h3FF, 16'hA3FF, "R5 dma top"); go();
    dsp_set(0, 11'h400, 16'h0000, "R5 dsp blocked"); go();
    dma_set(1, 10'd5, 16'h5555, ""); go();
    dsp_set(0, 11'd5, 16'h1111, "R3 priv untouched"); go();

    // R6 double, no swap
    cfg_set(3'b001); go();
    dsp_set(0, 11'h400, 16'hA000, "R11 dsp lower half"); go();
    dsp_set(0, 11'h600, 16'h0000, "R6 dsp upper blocked"); go();
    dma_set(0, 10'd0, 16'hA200, "R11 dma upper half"); go();
    dma_set(0, 10'h200, 16'h0000, "R6 dma high blocked"); go();
    chk(viol == 1, "R9 double", 16'(viol), 1);
    dma_set(1, 10'd1, 16'hB001, "");
    dsp_set(1, 11'h401, 16'hC001, "");
    go();

    // R7 swap
    cfg_set(3'b101); go();
    dsp_set(0, 11'h401, 16'hB001, "R7 dsp sees dma data");
    dma_set(0, 10'd1, 16'hC001, "R7 dma sees dsp data");
    go();
    dma_set(0, 10'd0, 16'hA000, "R7 dma lower half"); go();
    dsp_set(0, 11'h400, 16'hA200, "R7 dsp upper half"); go();
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule